// File: doc/BRIEF.md
# Guest-to-Shadow Root Pointer Cache

This block sits beside the address translation root register of a virtualised core. When a guest operating system switches context, it writes a new page-table root pointer. Under shadow translation, the hardware must swap in the root of the shadow table that the hypervisor built for that guest table. The block keeps a small fully associative set of pairs, each a guest root value and its shadow root value. It is searched on every guest root write. On a hit, the shadow root register is loaded one cycle later and the guest continues without an exit. On a miss, a trap request is raised so that the hypervisor can handle the switch in software.

Only the hypervisor changes the contents, through a separate management port. It can install a pair, drop the pair for one guest value, or flush all pairs. An install for a guest value that is already present rewrites that pair in place. A new value takes the lowest free slot. When every slot is in use, the new value replaces a slot chosen in round-robin order. Lookups never fill the cache. Building shadow tables and handling the trap are left to software.

Top module: `rootmap_cache`

## Requirements
- R1: After synchronous reset (rst_n low at a rising edge), shadow_root is 0, shadow_load and trap_req are 0, and every slot is empty, so any lookup misses.
- R2: A lookup (cs_valid high at edge N) whose cs_guest matches a valid slot gives shadow_load = 1 and trap_req = 0 after edge N, and shadow_root then holds that slot's shadow value.
- R3: A lookup that matches no valid slot gives trap_req = 1 and shadow_load = 0 after edge N, and leaves shadow_root unchanged.
- R4: In a cycle without cs_valid, neither shadow_load nor trap_req is raised after the following edge, and both are single-cycle pulses.
- R5: An install (mg_op = 1) whose mg_guest already has a valid slot replaces that slot's shadow value and occupies no other slot.
- R6: An install of a guest value with no slot goes to the lowest-numbered empty slot when one exists, and evicts nothing.
- R7: An install of a new guest value while all slots are valid replaces the slot named by a round-robin pointer. The pointer is 0 after reset, advances by one after each such replacement, and wraps from the last slot to slot 0.
- R8: A drop (mg_op = 2) clears only the slot matching mg_guest. A drop that matches no slot changes nothing.
- R9: A flush (mg_op = 3) empties every slot at once.
- R10: Management commands act only while mg_valid is high. mg_op = 0 is no operation.
- R11: A lookup in the same cycle as a management command sees the contents from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mg_valid | input | 1 | Management command strobe |
| mg_op | input | 2 | 0 none, 1 install, 2 drop, 3 flush |
| mg_guest | input | PTR_W | Guest root value named by the command |
| mg_shadow | input | PTR_W | Shadow root value for an install |
| cs_valid | input | 1 | Guest root write strobe (lookup request) |
| cs_guest | input | PTR_W | Guest root value being loaded |
| shadow_root | output | PTR_W | Shadow root register |
| shadow_load | output | 1 | Pulse: shadow_root was loaded from a hit |
| trap_req | output | 1 | Pulse: lookup missed, hypervisor exit required |

## Verification
The bench builds the block with NUM_ENTRIES = 4 and PTR_W = 24. With four slots, a handful of installs fill the cache, and five further installs take the round-robin pointer through all slots and back to slot 0. That makes the wrap of R7 observable as a specific guest value that starts missing. The 24-bit pointer values differ only in their upper and lower digits, so a partial comparison would show up as a false hit. Eviction, in-place update and slot reuse are all judged from which guest values still hit, because lookups are the only window onto the contents.

// File: rtl/rootmap_pkg.sv
// Shared definitions for the guest-to-shadow root pointer cache.
// Assumes: the management opcode is two bits wide.
package rootmap_pkg;
    typedef enum logic [1:0] {
        MG_NONE      = 2'd0,
        MG_INSTALL   = 2'd1,
        MG_DROP      = 2'd2,
        MG_FLUSH_ALL = 2'd3
    } mg_op_e;
endpackage

// File: rtl/rootmap_match.sv
// Fully associative tag comparison over all slots.
// Produces a per-slot hit vector, a hit flag and the encoded index of the hit.
// Assumes: at most one valid slot holds any given key (kept so by the top).
module rootmap_match #(
    parameter int unsigned NUM_ENTRIES = 8,
    parameter int unsigned PTR_W       = 40,
    localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [NUM_ENTRIES-1:0]            ent_valid,
    input  logic [NUM_ENTRIES-1:0][PTR_W-1:0] ent_guest,
    input  logic [PTR_W-1:0]                  key,
    output logic [NUM_ENTRIES-1:0]            hit_vec,
    output logic                              hit,
    output logic [IDX_W-1:0]                  hit_idx
);
    // One comparator per slot.
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = ent_valid[i] && (ent_guest[i] == key);
    end

    assign hit = |hit_vec;

    // Encode the hit vector into a slot index.
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/rootmap_alloc.sv
// Chooses the slot for a new guest value: the lowest empty slot, or the
// round-robin victim when all slots are valid.
// Assumes: advance is raised only for an install that replaces a valid slot.
module rootmap_alloc #(
    parameter int unsigned NUM_ENTRIES = 8,
    localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_ENTRIES-1:0] ent_valid,
    input  logic                   advance,
    output logic                   full,
    output logic [IDX_W-1:0]       slot_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;

    assign full = &ent_valid;

    // Find the lowest-numbered empty slot.
    always_comb begin
        free_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_idx = IDX_W'(i);
        end
    end

    // Step the round-robin victim pointer after each replacement.
    always_ff @(posedge clk) begin
        if (!rst_n)        rr_ptr <= '0;
        else if (advance)  rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
    end

    assign slot_idx = full ? rr_ptr : free_idx;

    // R7: each replacement moves the pointer on by one, wrapping at the end.
    assert_rr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (rr_ptr == (($past(rr_ptr) == LAST_IDX) ? '0 : $past(rr_ptr) + 1'b1)));

    // R6: with room left, the chosen slot is an empty one.
    assert_slot_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !full |-> !ent_valid[slot_idx]);
endmodule

// File: rtl/rootmap_store.sv
// Slot storage: a valid bit, a guest value and a shadow value per slot.
// Flush wins over a write and a clear in the same cycle.
// Assumes: wr_idx and clr_idx are below NUM_ENTRIES.
module rootmap_store #(
    parameter int unsigned NUM_ENTRIES = 8,
    parameter int unsigned PTR_W       = 40,
    localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [PTR_W-1:0]                  wr_guest,
    input  logic [PTR_W-1:0]                  wr_shadow,
    input  logic                              clr_en,
    input  logic [IDX_W-1:0]                  clr_idx,
    input  logic                              flush,
    output logic [NUM_ENTRIES-1:0]            ent_valid,
    output logic [NUM_ENTRIES-1:0][PTR_W-1:0] ent_guest,
    output logic [NUM_ENTRIES-1:0][PTR_W-1:0] ent_shadow
);
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
        logic sel_wr;
        logic sel_clr;
        assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(i));
        assign sel_clr = clr_en && (clr_idx == IDX_W'(i));

        // Maintain the valid bit of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) ent_valid[i] <= 1'b0;
            else if (sel_wr)     ent_valid[i] <= 1'b1;
            else if (sel_clr)    ent_valid[i] <= 1'b0;
        end

        // Capture the pointer pair of this slot on a write.
        always_ff @(posedge clk) begin
            if (sel_wr) begin
                ent_guest[i]  <= wr_guest;
                ent_shadow[i] <= wr_shadow;
            end
        end
    end

    // R9: a flush leaves no slot valid.
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ent_valid == '0));
endmodule

// File: rtl/rootmap_cache.sv
// Guest-to-shadow root pointer cache (top).
// Searches the slots on a guest root write. A hit loads the shadow root
// register, a miss raises a trap request; both results come one cycle later.
// The hypervisor installs, drops and flushes pairs through the management port.
// Assumes: a lookup and a command in the same cycle both use the pre-edge contents.
module rootmap_cache #(
    parameter int unsigned NUM_ENTRIES = 8,
    parameter int unsigned PTR_W       = 40,
    localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mg_valid,
    input  logic [1:0]       mg_op,
    input  logic [PTR_W-1:0] mg_guest,
    input  logic [PTR_W-1:0] mg_shadow,
    input  logic             cs_valid,
    input  logic [PTR_W-1:0] cs_guest,
    output logic [PTR_W-1:0] shadow_root,
    output logic             shadow_load,
    output logic             trap_req
);
    import rootmap_pkg::*;

    logic [NUM_ENTRIES-1:0]            ent_valid;
    logic [NUM_ENTRIES-1:0][PTR_W-1:0] ent_guest;
    logic [NUM_ENTRIES-1:0][PTR_W-1:0] ent_shadow;

    logic [NUM_ENTRIES-1:0] lk_vec, mg_vec;
    logic                   lk_hit, mg_hit;
    logic [IDX_W-1:0]       lk_idx, mg_idx;
    logic                   full;
    logic [IDX_W-1:0]       slot_idx;

    mg_op_e op;
    logic   do_install, do_drop, do_flush, do_evict;

    assign op         = mg_op_e'(mg_op);
    assign do_install = mg_valid && (op == MG_INSTALL);
    assign do_drop    = mg_valid && (op == MG_DROP);
    assign do_flush   = mg_valid && (op == MG_FLUSH_ALL);
    assign do_evict   = do_install && !mg_hit && full;

    rootmap_match #(.NUM_ENTRIES(NUM_ENTRIES), .PTR_W(PTR_W)) u_lookup_match (
        .ent_valid (ent_valid),
        .ent_guest (ent_guest),
        .key       (cs_guest),
        .hit_vec   (lk_vec),
        .hit       (lk_hit),
        .hit_idx   (lk_idx)
    );

    rootmap_match #(.NUM_ENTRIES(NUM_ENTRIES), .PTR_W(PTR_W)) u_mgmt_match (
        .ent_valid (ent_valid),
        .ent_guest (ent_guest),
        .key       (mg_guest),
        .hit_vec   (mg_vec),
        .hit       (mg_hit),
        .hit_idx   (mg_idx)
    );

    rootmap_alloc #(.NUM_ENTRIES(NUM_ENTRIES)) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ent_valid (ent_valid),
        .advance   (do_evict),
        .full      (full),
        .slot_idx  (slot_idx)
    );

    rootmap_store #(.NUM_ENTRIES(NUM_ENTRIES), .PTR_W(PTR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (do_install),
        .wr_idx     (mg_hit ? mg_idx : slot_idx),
        .wr_guest   (mg_guest),
        .wr_shadow  (mg_shadow),
        .clr_en     (do_drop && mg_hit),
        .clr_idx    (mg_idx),
        .flush      (do_flush),
        .ent_valid  (ent_valid),
        .ent_guest  (ent_guest),
        .ent_shadow (ent_shadow)
    );

    // Register the lookup result and load the shadow root on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_root <= '0;
            shadow_load <= 1'b0;
            trap_req    <= 1'b0;
        end else begin
            shadow_load <= cs_valid && lk_hit;
            trap_req    <= cs_valid && !lk_hit;
            if (cs_valid && lk_hit) shadow_root <= ent_shadow[lk_idx];
        end
    end

    // R5: in-place update keeps every guest value in at most one slot.
    assert_single_lookup_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));
    assert_single_mgmt_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mg_vec));

    // R2: every lookup is answered in the next cycle.
    assert_lookup_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_valid |=> (shadow_load || trap_req));

    // R3: hit and trap never coincide, and a miss keeps the root.
    assert_load_trap_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(shadow_load && trap_req));
    assert_miss_keeps_root_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $stable(shadow_root));

    // R4: without a lookup, nothing is signalled.
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_valid |=> (!shadow_load && !trap_req));

    // R10: an installed value is present in the next cycle unless flushed.
    assert_install_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        do_install |=> ent_valid[$past(mg_hit ? mg_idx : slot_idx)]);
endmodule

// File: tb/tb_rootmap_cache.sv
// Directed bench for rootmap_cache, built with 4 slots and 24-bit pointers.
module tb_rootmap_cache;
    localparam int unsigned N = 4;
    localparam int unsigned W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mg_valid = 1'b0;
    logic [1:0]   mg_op = 2'd0;
    logic [W-1:0] mg_guest = '0;
    logic [W-1:0] mg_shadow = '0;
    logic         cs_valid = 1'b0;
    logic [W-1:0] cs_guest = '0;
    logic [W-1:0] shadow_root;
    logic         shadow_load;
    logic         trap_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [W-1:0] exp_root = '0;

    always #4 clk = ~clk;

    rootmap_cache #(.NUM_ENTRIES(N), .PTR_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .mg_valid(mg_valid), .mg_op(mg_op), .mg_guest(mg_guest), .mg_shadow(mg_shadow),
        .cs_valid(cs_valid), .cs_guest(cs_guest),
        .shadow_root(shadow_root), .shadow_load(shadow_load), .trap_req(trap_req)
    );

    // Guest values and their shadow partners.
    function automatic logic [W-1:0] gv(int k);
        return W'(24'hA00000 + k * 24'h010001);
    endfunction
    function automatic logic [W-1:0] sv(int k);
        return W'(24'h500000 + k * 24'h001110);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_root = '0;
    endtask

    task automatic mgmt(logic [1:0] op, logic [W-1:0] g, logic [W-1:0] s);
        @(negedge clk);
        mg_valid = 1'b1; mg_op = op; mg_guest = g; mg_shadow = s;
        @(negedge clk);
        mg_valid = 1'b0; mg_op = 2'd0;
    endtask

    task automatic expect_hit(string tag, logic [W-1:0] g, logic [W-1:0] s);
        @(negedge clk);
        cs_valid = 1'b1; cs_guest = g;
        @(negedge clk);
        cs_valid = 1'b0;
        chk({tag, " load"}, 64'(shadow_load), 64'd1);
        chk({tag, " trap"}, 64'(trap_req), 64'd0);
        chk({tag, " root"}, 64'(shadow_root), 64'(s));
        exp_root = s;
    endtask

    task automatic expect_miss(string tag, logic [W-1:0] g);
        @(negedge clk);
        cs_valid = 1'b1; cs_guest = g;
        @(negedge clk);
        cs_valid = 1'b0;
        chk({tag, " trap"}, 64'(trap_req), 64'd1);
        chk({tag, " load"}, 64'(shadow_load), 64'd0);
        chk({tag, " root kept"}, 64'(shadow_root), 64'(exp_root));
    endtask

    // R1, R4: reset state and quiet idle cycles.
    task automatic t_reset_idle();
        do_reset();
        chk("R1 root", 64'(shadow_root), 64'd0);
        chk("R1 load", 64'(shadow_load), 64'd0);
        chk("R1 trap", 64'(trap_req), 64'd0);
        expect_miss("R1 empty after reset", '0);
        repeat (3) begin
            @(negedge clk);
            chk("R4 idle load", 64'(shadow_load), 64'd0);
            chk("R4 idle trap", 64'(trap_req), 64'd0);
        end
    endtask

    // R2, R3, R4: basic hit and miss, pulses last one cycle.
    task automatic t_basic();
        do_reset();
        mgmt(2'd1, gv(0), sv(0));
        expect_hit("R2 hit", gv(0), sv(0));
        @(negedge clk);
        chk("R4 load one cycle", 64'(shadow_load), 64'd0);
        expect_miss("R3 miss", gv(9));
        @(negedge clk);
        chk("R4 trap one cycle", 64'(trap_req), 64'd0);
        expect_miss("R3 near value miss", gv(0) ^ 24'h800000);
    endtask

    // R5: rewrite in place uses no second slot.
    task automatic t_inplace();
        do_reset();
        mgmt(2'd1, gv(0), sv(0));
        mgmt(2'd1, gv(0), sv(7));
        for (int k = 1; k < N; k++) mgmt(2'd1, gv(k), sv(k));
        expect_hit("R5 updated value", gv(0), sv(7));
        for (int k = 1; k < N; k++) expect_hit("R5 no slot lost", gv(k), sv(k));
    endtask

    // R6, R8: drop frees one slot, a new value reuses it.
    task automatic t_reuse();
        do_reset();
        for (int k = 0; k < N; k++) mgmt(2'd1, gv(k), sv(k));
        mgmt(2'd2, gv(9), '0);
        for (int k = 0; k < N; k++) expect_hit("R8 stray drop no effect", gv(k), sv(k));
        mgmt(2'd2, gv(1), '0);
        expect_miss("R8 dropped value", gv(1));
        expect_hit("R8 others kept", gv(2), sv(2));
        mgmt(2'd1, gv(5), sv(5));
        expect_hit("R6 reused slot", gv(5), sv(5));
        expect_hit("R6 nothing evicted a", gv(0), sv(0));
        expect_hit("R6 nothing evicted b", gv(3), sv(3));
    endtask

    // R7: round-robin replacement with wrap.
    task automatic t_round_robin();
        do_reset();
        for (int k = 0; k < N; k++) mgmt(2'd1, gv(k), sv(k));
        mgmt(2'd1, gv(4), sv(4));
        expect_miss("R7 slot0 evicted", gv(0));
        for (int k = 1; k <= 4; k++) expect_hit("R7 after first eviction", gv(k), sv(k));
        mgmt(2'd1, gv(5), sv(5));
        expect_miss("R7 slot1 evicted", gv(1));
        mgmt(2'd1, gv(6), sv(6));
        mgmt(2'd1, gv(7), sv(7));
        mgmt(2'd1, gv(8), sv(8));
        expect_miss("R7 wrapped to slot0", gv(4));
        for (int k = 5; k <= 8; k++) expect_hit("R7 after wrap", gv(k), sv(k));
    endtask

    // R9, R10: flush, and commands ignored without mg_valid.
    task automatic t_flush();
        do_reset();
        for (int k = 0; k < N; k++) mgmt(2'd1, gv(k), sv(k));
        @(negedge clk);
        mg_op = 2'd3; mg_guest = gv(0);
        @(negedge clk);
        mg_op = 2'd0;
        expect_hit("R10 flush without valid ignored", gv(2), sv(2));
        mgmt(2'd0, gv(3), sv(9));
        expect_hit("R10 no-op opcode", gv(3), sv(3));
        mgmt(2'd3, '0, '0);
        for (int k = 0; k < N; k++) expect_miss("R9 flushed", gv(k));
    endtask

    // R11: lookup in the same cycle as a command sees old contents.
    task automatic t_same_cycle();
        do_reset();
        mgmt(2'd1, gv(0), sv(0));
        @(negedge clk);
        cs_valid = 1'b1; cs_guest = gv(0);
        mg_valid = 1'b1; mg_op = 2'd1; mg_guest = gv(0); mg_shadow = sv(6);
        @(negedge clk);
        cs_valid = 1'b0; mg_valid = 1'b0; mg_op = 2'd0;
        chk("R11 update sees old", 64'(shadow_root), 64'(sv(0)));
        exp_root = sv(0);
        expect_hit("R11 update then new", gv(0), sv(6));
        @(negedge clk);
        cs_valid = 1'b1; cs_guest = gv(0);
        mg_valid = 1'b1; mg_op = 2'd2; mg_guest = gv(0);
        @(negedge clk);
        cs_valid = 1'b0; mg_valid = 1'b0; mg_op = 2'd0;
        chk("R11 drop sees old", 64'(shadow_load), 64'd1);
        expect_miss("R11 dropped after", gv(0));
        @(negedge clk);
        cs_valid = 1'b1; cs_guest = gv(3);
        mg_valid = 1'b1; mg_op = 2'd1; mg_guest = gv(3); mg_shadow = sv(3);
        @(negedge clk);
        cs_valid = 1'b0; mg_valid = 1'b0; mg_op = 2'd0;
        chk("R11 install not yet seen", 64'(trap_req), 64'd1);
        expect_hit("R11 install seen next", gv(3), sv(3));
    endtask

    initial begin
        t_reset_idle();
        t_basic();
        t_inplace();
        t_reuse();
        t_round_robin();
        t_flush();
        t_same_cycle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule